// File: doc/BRIEF.md
# Quad Nibble Command Front End

This block is the slave-side entry point of a serial flash device with a 4-bit data bus. It samples the serial clock, chip select and the four data lines in the system clock domain. While chip select is low, it builds the opening byte of each transaction from two nibbles taken on rising serial-clock edges, high nibble first. It also keeps track of whether any nibbles arrive after that opening byte.

Three commands are handled locally. Write-enable sets the write-enable latch, write-disable clears it, and both take effect only when chip select rises. Status read returns the status byte on the bus. The data changes on falling serial-clock edges, and the output drivers are turned on only for this phase. Every other opcode is passed to downstream engines as a one-cycle strobe with the opcode attached. A permit flag on that strobe tells the engine whether it may run: it is low when the opcode belongs to the latch-gated group and the latch is clear. While the device reports busy, the block accepts only status read and the suspend opcode.

Top module: `qnf_front`

## Requirements
- R1: Only the first byte of a transaction is decoded as the command. It is formed as {nibble on the first rising edge, nibble on the second rising edge}. Later nibbles in the same transaction never produce a strobe.
- R2: When chip select rises, any half-received byte is discarded. The next transaction starts again with a high nibble.
- R3: Opcode 8'h06 sets `wel`. The change appears only after chip select rises; `wel` holds its old value while chip select is still low.
- R4: Opcode 8'h04 clears `wel` after chip select rises.
- R5: An 8'h06 or 8'h04 command that is followed by one or more further nibbles before chip select rises leaves `wel` unchanged.
- R6: After opcode 8'h05, the status byte is driven on `sio_out`. The high nibble is driven on the first falling edge, and the low nibble on the next falling edge. Bit 0 is busy, bit 1 is `wel`, bit 6 is the program-suspended input, bit 7 is the erase-suspended input, and bits 5..2 are zero.
- R7: The status byte repeats, high nibble then low nibble, for as long as chip select stays low.
- R8: Status read works while `busy_i` is high, and reports busy as 1.
- R9: `sio_oe` is low except in a status-read transaction, from the first falling edge after the opcode until chip select rises.
- R10: Any opcode other than 8'h06, 8'h04 and 8'h05 gives exactly one `cmd_stb` pulse, with `cmd_code` equal to the opcode. `cmd_permit` is 0 only when the opcode is one of 8'h20, 8'hD8, 8'hC7, 8'h02, 8'hA5, 8'h85, 8'h42, 8'h8D and `wel` is 0.
- R11: While `busy_i` is high, every opcode except 8'h05 and 8'hB0 is ignored: it gives no strobe and causes no change to `wel`. 8'hB0 is still strobed.
- R12: After reset, `wel` is 0, `sio_oe` is 0 and `cmd_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial bus clock |
| csn | input | 1 | Chip select, active low |
| sio_in | input | 4 | Nibble from the host |
| sio_out | output | 4 | Nibble driven to the host |
| sio_oe | output | 1 | Output enable for the data lines |
| busy_i | input | 1 | Device busy with a self-timed write |
| esus_i | input | 1 | Erase suspended |
| psus_i | input | 1 | Program suspended |
| wel | output | 1 | Write-enable latch |
| cmd_stb | output | 1 | One-cycle strobe for a forwarded opcode |
| cmd_code | output | 8 | Forwarded opcode |
| cmd_permit | output | 1 | Forwarded opcode may execute |

## Verification
If the nibble phase is wrong, every later opcode arrives with its nibbles swapped. This shows up on `cmd_code`, or as a missing or extra strobe, within a cycle of the second rising edge. A wrong latch or pending-update state first shows as an unexpected `wel` a cycle or two after chip select rises. It then spreads to `cmd_permit` and to bit 1 of the status byte. A broken output sequencer gives a wrong nibble on `sio_out`, or an `sio_oe` that stays high, within two system clocks of the serial-clock or chip-select edge that should have moved it.

// File: rtl/qnf_pkg.sv
package qnf_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_SUSP = 8'hB0;

  // status bit positions
  localparam int ST_BUSY = 0;
  localparam int ST_WEL  = 1;
  localparam int ST_PSUS = 6;
  localparam int ST_ESUS = 7;

  // opcodes that may only run with the write-enable latch set
  function automatic logic needs_wel(input logic [7:0] op);
    case (op)
      8'h20, 8'hD8, 8'hC7, 8'h02, 8'hA5, 8'h85, 8'h42, 8'h8D: needs_wel = 1'b1;
      default: needs_wel = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/qnf_edge.sv
module qnf_edge #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sck,
  input  logic             csn,
  input  logic [NIB_W-1:0] sio_in,
  output logic             sck_rise,
  output logic             sck_fall,
  output logic             cs_act,
  output logic             cs_up,
  output logic [NIB_W-1:0] sio_q
);
  logic sck_q, sck_p, csn_q, csn_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      sck_p <= 1'b0;
      csn_q <= 1'b1;
      csn_p <= 1'b1;
      sio_q <= '0;
    end else begin
      sck_q <= sck;
      sck_p <= sck_q;
      csn_q <= csn;
      csn_p <= csn_q;
      sio_q <= sio_in;
    end
  end

  assign cs_act   = ~csn_q;
  assign cs_up    = csn_q & ~csn_p;
  assign sck_rise = sck_q & ~sck_p & ~csn_q;
  assign sck_fall = ~sck_q & sck_p & ~csn_q;
endmodule

// File: rtl/qnf_nibasm.sv
module qnf_nibasm #(
  parameter int NIB_W = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic              cs_act,
  input  logic [NIB_W-1:0]  sio,
  output logic              cmd_done,
  output logic [BYTE_W-1:0] cmd_val,
  output logic              past_cmd
);
  logic             lo_ph;
  logic [NIB_W-1:0] hi_nib;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_ph    <= 1'b0;
      hi_nib   <= '0;
      past_cmd <= 1'b0;
      cmd_done <= 1'b0;
      cmd_val  <= '0;
    end else if (!cs_act) begin
      lo_ph    <= 1'b0;
      past_cmd <= 1'b0;
      cmd_done <= 1'b0;
    end else begin
      cmd_done <= 1'b0;
      if (rise) begin
        if (!lo_ph) begin
          hi_nib <= sio;
          lo_ph  <= 1'b1;
        end else begin
          lo_ph <= 1'b0;
          if (!past_cmd) begin
            cmd_done <= 1'b1;
            cmd_val  <= {hi_nib, sio};
            past_cmd <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/qnf_stat.sv
module qnf_stat #(
  parameter int NIB_W = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall,
  input  logic              cs_act,
  input  logic              start,
  input  logic [BYTE_W-1:0] stat,
  output logic [NIB_W-1:0]  sio_out,
  output logic              sio_oe
);
  logic             rd_act, lo_next;
  logic [NIB_W-1:0] lo_snap;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act  <= 1'b0;
      lo_next <= 1'b0;
      lo_snap <= '0;
      sio_out <= '0;
      sio_oe  <= 1'b0;
    end else if (!cs_act) begin
      rd_act  <= 1'b0;
      lo_next <= 1'b0;
      sio_oe  <= 1'b0;
    end else begin
      if (start) rd_act <= 1'b1;
      if (fall && rd_act) begin
        sio_oe <= 1'b1;
        if (!lo_next) begin
          sio_out <= stat[BYTE_W-1:NIB_W];
          lo_snap <= stat[NIB_W-1:0];
          lo_next <= 1'b1;
        end else begin
          sio_out <= lo_snap;
          lo_next <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/qnf_front.sv
module qnf_front
  import qnf_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              csn,
  input  logic [NIB_W-1:0]  sio_in,
  output logic [NIB_W-1:0]  sio_out,
  output logic              sio_oe,
  input  logic              busy_i,
  input  logic              esus_i,
  input  logic              psus_i,
  output logic              wel,
  output logic              cmd_stb,
  output logic [BYTE_W-1:0] cmd_code,
  output logic              cmd_permit
);
  logic              sck_rise, sck_fall, cs_act, cs_up;
  logic [NIB_W-1:0]  sio_q;
  logic              cmd_done, past_cmd;
  logic [BYTE_W-1:0] cmd_val;
  logic              pend_set, pend_clr;
  logic [BYTE_W-1:0] stat;
  logic              rd_start;

  qnf_edge #(.NIB_W(NIB_W)) u_edge (
    .clk(clk), .rst(rst), .sck(sck), .csn(csn), .sio_in(sio_in),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act),
    .cs_up(cs_up), .sio_q(sio_q)
  );

  qnf_nibasm #(.NIB_W(NIB_W)) u_asm (
    .clk(clk), .rst(rst), .rise(sck_rise), .cs_act(cs_act), .sio(sio_q),
    .cmd_done(cmd_done), .cmd_val(cmd_val), .past_cmd(past_cmd)
  );

  always_comb begin
    stat          = '0;
    stat[ST_BUSY] = busy_i;
    stat[ST_WEL]  = wel;
    stat[ST_PSUS] = psus_i;
    stat[ST_ESUS] = esus_i;
  end

  assign rd_start = cmd_done && (cmd_val == BYTE_W'(OP_RDSR));

  qnf_stat #(.NIB_W(NIB_W)) u_stat (
    .clk(clk), .rst(rst), .fall(sck_fall), .cs_act(cs_act),
    .start(rd_start), .stat(stat), .sio_out(sio_out), .sio_oe(sio_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wel        <= 1'b0;
      pend_set   <= 1'b0;
      pend_clr   <= 1'b0;
      cmd_stb    <= 1'b0;
      cmd_code   <= '0;
      cmd_permit <= 1'b0;
    end else begin
      cmd_stb <= 1'b0;
      if (!cs_act) begin
        if (cs_up) begin
          if (pend_set)      wel <= 1'b1;
          else if (pend_clr) wel <= 1'b0;
        end
        pend_set <= 1'b0;
        pend_clr <= 1'b0;
      end else begin
        if (sck_rise && past_cmd) begin
          pend_set <= 1'b0;
          pend_clr <= 1'b0;
        end
        if (cmd_done) begin
          if (cmd_val == BYTE_W'(OP_WREN)) begin
            pend_set <= !busy_i;
            pend_clr <= 1'b0;
          end else if (cmd_val == BYTE_W'(OP_WRDI)) begin
            pend_clr <= !busy_i;
            pend_set <= 1'b0;
          end else if (cmd_val != BYTE_W'(OP_RDSR)) begin
            if (!busy_i || cmd_val == BYTE_W'(OP_SUSP)) begin
              cmd_stb    <= 1'b1;
              cmd_code   <= cmd_val;
              cmd_permit <= !needs_wel(8'(cmd_val)) || wel;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/qnf_front_chk.sv
module qnf_front_chk #(
  parameter int NIB_W = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_act,
  input logic              cs_up,
  input logic              wel,
  input logic              sio_oe,
  input logic              cmd_stb,
  input logic [BYTE_W-1:0] cmd_code,
  input logic              cmd_permit,
  input logic              busy_i
);
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !sio_oe);                                              // R9
  AST_WEL_AT_CS_RISE: assert property (@(posedge clk) disable iff (rst)
    !cs_up |=> $stable(wel));                                          // R3
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |=> !cmd_stb);                                             // R10
  AST_PERMIT_GATE: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && !cmd_permit) |-> !wel);                                // R10
  AST_BUSY_FILTER: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> (!$past(busy_i) || cmd_code == BYTE_W'(8'hB0)));       // R11
endmodule

bind qnf_front qnf_front_chk #(.NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .cs_up(cs_up), .wel(wel),
  .sio_oe(sio_oe), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
  .cmd_permit(cmd_permit), .busy_i(busy_i)
);

// File: tb/sim_qnf_front.sv
`timescale 1ns/1ps
module sim_qnf_front;
  logic clk = 1'b0;
  logic rst, sck, csn, busy_i, esus_i, psus_i;
  logic [3:0] sio_in, sio_out;
  logic sio_oe, wel, cmd_stb, cmd_permit;
  logic [7:0] cmd_code;

  int checks = 0, errors = 0, stb_cnt = 0;
  logic [7:0] last_code;
  logic last_perm;
  logic m_wel = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  qnf_front u0 (
    .clk(clk), .rst(rst), .sck(sck), .csn(csn), .sio_in(sio_in),
    .sio_out(sio_out), .sio_oe(sio_oe), .busy_i(busy_i), .esus_i(esus_i),
    .psus_i(psus_i), .wel(wel), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .cmd_permit(cmd_permit)
  );

  always @(negedge clk) if (!rst && cmd_stb) begin
    stb_cnt++;
    last_code = cmd_code;
    last_perm = cmd_permit;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (4) @(negedge clk);
  endtask

  task automatic send_nib(input logic [3:0] n);
    sck = 1'b0; sio_in = n; wait_h();
    sck = 1'b1; wait_h();
  endtask

  function automatic bit prot(input logic [7:0] c);
    case (c)
      8'h20, 8'hD8, 8'hC7, 8'h02, 8'hA5, 8'h85, 8'h42, 8'h8D: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] st_exp();
    return {esus_i, psus_i, 4'b0000, m_wel, busy_i};
  endfunction

  task automatic do_cmd(input logic [7:0] c, input int extra);
    int n0 = stb_cnt;
    logic w0 = m_wel;
    bit exp_stb;
    string tag;
    tag = (c == 8'h06) ? "R3" : (c == 8'h04) ? "R4" : "R10";
    if (extra > 0 && (c == 8'h06 || c == 8'h04)) tag = "R5";
    if (busy_i) tag = "R11";
    csn = 1'b0; wait_h();
    send_nib(c[7:4]);
    send_nib(c[3:0]);
    for (int i = 0; i < extra; i++) send_nib(4'($urandom));
    if (c == 8'h06 || c == 8'h04)
      chk(wel === m_wel, "R3", "wel before cs rise", wel, m_wel);
    sck = 1'b0; wait_h();
    csn = 1'b1; wait_h();
    if (!busy_i && extra == 0) begin
      if (c == 8'h06) m_wel = 1'b1;
      if (c == 8'h04) m_wel = 1'b0;
    end
    exp_stb = !(c == 8'h06 || c == 8'h04 || c == 8'h05) && (!busy_i || c == 8'hB0);
    chk(stb_cnt - n0 == int'(exp_stb), (extra > 0) ? "R1" : tag, "strobe count",
        stb_cnt - n0, int'(exp_stb));
    if (exp_stb && stb_cnt - n0 == 1) begin
      chk(last_code === c, "R1", "cmd_code", last_code, c);
      chk(last_perm === (!prot(c) || w0), "R10", "cmd_permit", last_perm, !prot(c) || w0);
    end
    chk(wel === m_wel, tag, "wel after cs rise", wel, m_wel);
    chk(sio_oe === 1'b0, "R9", "oe outside status", sio_oe, 0);
  endtask

  task automatic do_rdsr(input int nbytes);
    int n0 = stb_cnt;
    logic [7:0] s;
    string tag;
    csn = 1'b0; wait_h();
    send_nib(4'h0);
    send_nib(4'h5);
    chk(sio_oe === 1'b0, "R9", "oe before first fall", sio_oe, 0);
    s = st_exp();
    for (int b = 0; b < nbytes; b++) begin
      tag = busy_i ? "R8" : (b > 0) ? "R7" : "R6";
      sck = 1'b0; wait_h();
      chk(sio_oe === 1'b1, "R9", "oe in status phase", sio_oe, 1);
      chk(sio_out === s[7:4], tag, "status high nibble", sio_out, s[7:4]);
      sck = 1'b1; wait_h();
      sck = 1'b0; wait_h();
      chk(sio_out === s[3:0], tag, "status low nibble", sio_out, s[3:0]);
      sck = 1'b1; wait_h();
    end
    csn = 1'b1; wait_h();
    sck = 1'b0;
    chk(sio_oe === 1'b0, "R9", "oe after cs rise", sio_oe, 0);
    chk(stb_cnt == n0, "R10", "no strobe for status read", stb_cnt - n0, 0);
  endtask

  function automatic logic [7:0] pick_op(input int k);
    case (k)
      0: return 8'h06;  1: return 8'h04;  2: return 8'h05;  3: return 8'h20;
      4: return 8'hD8;  5: return 8'hC7;  6: return 8'h02;  7: return 8'hA5;
      8: return 8'h85;  9: return 8'h42;  10: return 8'h8D; 11: return 8'hB0;
      12: return 8'h30; 13: return 8'h03; default: return 8'h9F;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; csn = 1'b1; sck = 1'b0; sio_in = 4'h0;
    busy_i = 1'b0; esus_i = 1'b0; psus_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(wel === 1'b0, "R12", "wel at reset", wel, 0);
    chk(sio_oe === 1'b0, "R12", "oe at reset", sio_oe, 0);
    chk(cmd_stb === 1'b0, "R12", "strobe at reset", cmd_stb, 0);
    rst = 1'b0;
    wait_h();

    do_cmd(8'h06, 0);                   // R3
    psus_i = 1'b1;
    do_rdsr(3);                         // R6 R7
    psus_i = 1'b0; esus_i = 1'b1;
    do_rdsr(1);
    esus_i = 1'b0;
    do_cmd(8'h04, 0);                   // R4
    do_cmd(8'h06, 2);                   // R5
    // R2: half byte then abort
    csn = 1'b0; wait_h();
    send_nib(4'h0);
    sck = 1'b0; wait_h();
    csn = 1'b1; wait_h();
    do_cmd(8'h06, 0);
    // R11 / R8 while busy
    busy_i = 1'b1;
    do_cmd(8'h04, 0);
    do_cmd(8'h20, 0);
    do_cmd(8'hB0, 0);
    do_rdsr(2);
    busy_i = 1'b0;
    // R10 gating both ways
    do_cmd(8'h04, 0);
    do_cmd(8'hD8, 0);
    do_cmd(8'h03, 0);
    do_cmd(8'h06, 0);
    do_cmd(8'hD8, 0);

    for (int t = 0; t < 250; t++) begin
      logic [7:0] op;
      busy_i = ($urandom_range(0, 3) == 0);
      esus_i = 1'($urandom);
      psus_i = 1'($urandom);
      op = pick_op($urandom_range(0, 14));
      if (op == 8'h05) do_rdsr($urandom_range(1, 3));
      else do_cmd(op, ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule